// File: doc/BRIEF.md
# Indexed Audio Codec Control Registers

This block is the control-register front end of an audio codec. A host reaches it over a plain 32-bit bus addressed in bytes: a read strobe, a write strobe, a byte address, write data and read data. The 64-byte window decodes into sixteen 32-bit direct words. Byte address bits [1:0] are ignored, so the word number is address bits [5:2].

Direct word 0 is a pointer. Its low five bits pick one of thirty-two 8-bit codec registers. Direct word 1 is a window onto the codec register that the pointer selects. Some codec registers follow special rules. One reads as zero. Two cannot be written. One carries a fixed version pattern that a write can only partly change. Direct word 2 cannot be written. Direct word 4 is a control word whose bit 0 returns both banks to their reset state.

Read data is registered and appears one cycle after the read strobe. The interrupt output exists but is always driven low.

Top module: `codec_regfile`

## Requirements
- R1: After the active-low synchronous reset, every direct word reads 0x00000000. Every codec register reads 0x00 through the window, except register 12, which reads 0x8A, and register 25, which reads 0xA0.
- R2: Every direct word other than 1, 2 and 4 stores all 32 written bits and returns them on a read. The word number is byte address bits [5:2], and address bits [1:0] have no effect.
- R3: A window access (word 1) reads or writes the codec register whose number is bits [4:0] of direct word 0. Direct word 0 itself keeps and returns all 32 bits.
- R4: A window read while the pointer selects register 3 returns 0x00000000, whatever was written to register 3.
- R5: Window writes to codec registers 11 and 25 are ignored. Those registers keep 0x00 and 0xA0.
- R6: A window write of value v to codec register 12 stores (v AND 0x40) OR 0x8A.
- R7: Writes to direct word 2 are ignored, and it keeps reading 0x00000000.
- R8: A write of v to direct word 4 stores v AND 0x0000007F. When bit 0 of v is 1, both banks first return to their R1 values, and word 4 then holds the masked v.
- R9: rdata is updated only in the cycle after a read strobe and otherwise holds its value. A read in the same cycle as a write returns the contents from before the write.
- R10: irq is always 0.
- R11: A window read returns the selected 8-bit register zero-extended to 32 bits. Only bits [7:0] of a window write are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 6 | Byte address within the 64-byte window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, held low |

## Verification
A wrong pointer, a missing write filter or a wrong clear order cannot be seen directly, because the block has no status outputs. Every such fault shows up only in the value returned two cycles after the access that reveals it: the cycle that stores the state, then the registered read. The bench therefore follows each write that matters with a window or direct read. It reads back neighbouring registers as well, so that a soft reset that leaves state behind, or a write that lands on the wrong index, shows up on the very next read.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;
  parameter int unsigned IND_W = 8;

  localparam int unsigned WORD_PTR  = 0;
  localparam int unsigned WORD_WIN  = 1;
  localparam int unsigned WORD_LOCK = 2;
  localparam int unsigned WORD_CTL  = 4;

  localparam int unsigned IDX_HIDDEN = 3;
  localparam int unsigned IDX_RO_A   = 11;
  localparam int unsigned IDX_VER    = 12;
  localparam int unsigned IDX_RO_B   = 25;

  localparam logic [7:0] VER_CODEC = 8'h8A;
  localparam logic [7:0] VER_CHIP  = 8'hA0;
  localparam logic [7:0] VER_KEEP  = 8'h40;
  localparam logic [31:0] CTL_MASK = 32'h0000_007F;

  function automatic logic [IND_W-1:0] ind_reset_val(input int unsigned idx);
    if (idx == IDX_VER) return IND_W'(VER_CODEC);
    if (idx == IDX_RO_B) return IND_W'(VER_CHIP);
    return '0;
  endfunction

  function automatic logic ind_writable(input int unsigned idx);
    return !(idx == IDX_RO_A || idx == IDX_RO_B);
  endfunction

  function automatic logic ind_readable(input int unsigned idx);
    return idx != IDX_HIDDEN;
  endfunction

  function automatic logic [IND_W-1:0] ind_write_val(input int unsigned idx,
                                                     input logic [IND_W-1:0] v);
    if (idx == IDX_VER) return (v & IND_W'(VER_KEEP)) | IND_W'(VER_CODEC);
    return v;
  endfunction

  function automatic logic [31:0] ctl_store(input logic [31:0] v);
    return v & CTL_MASK;
  endfunction
endpackage

// File: rtl/codec_indirect_bank.sv
module codec_indirect_bank
  import codec_regs_pkg::*;
#(
  parameter int unsigned N_IND = 32,
  localparam int unsigned IW = $clog2(N_IND)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        wr_en,
  input  logic [IW-1:0]               wr_idx,
  input  logic [IND_W-1:0]            wr_val,
  output logic [N_IND-1:0][IND_W-1:0] regs
);
  for (genvar g = 0; g < N_IND; g++) begin : g_reg
    if (ind_writable(g)) begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n || clear)
          regs[g] <= ind_reset_val(g);
        else if (wr_en && wr_idx == IW'(g))
          regs[g] <= ind_write_val(g, wr_val);
      end
    end else begin : g_ro
      always_ff @(posedge clk) begin
        regs[g] <= ind_reset_val(g);
      end
    end
  end

  if (N_IND > IDX_RO_B) begin : g_chk
    assert_ro_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
      regs[IDX_RO_A] == '0);
    assert_ro_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
      regs[IDX_RO_B] == IND_W'(VER_CHIP));
    assert_ver_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (regs[IDX_VER] & ~IND_W'(VER_KEEP)) == IND_W'(VER_CODEC));
  end
endmodule

// File: rtl/codec_direct_bank.sv
module codec_direct_bank
  import codec_regs_pkg::*;
#(
  parameter int unsigned N_DIRECT = 16,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned AW = $clog2(N_DIRECT)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_word,
  input  logic [DATA_W-1:0]             wr_val,
  output logic [N_DIRECT-1:0][DATA_W-1:0] words
);
  for (genvar g = 0; g < N_DIRECT; g++) begin : g_word
    if (g == WORD_WIN || g == WORD_LOCK) begin : g_none
      assign words[g] = '0;
    end else if (g == WORD_CTL) begin : g_ctl
      // store wins over clear: clear first, masked store last
      always_ff @(posedge clk) begin
        if (!rst_n)
          words[g] <= '0;
        else if (wr_en && wr_word == AW'(g))
          words[g] <= DATA_W'(ctl_store(32'(wr_val)));
        else if (clear)
          words[g] <= '0;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n || clear)
          words[g] <= '0;
        else if (wr_en && wr_word == AW'(g))
          words[g] <= wr_val;
      end
    end
  end
endmodule

// File: rtl/codec_read_port.sv
module codec_read_port
  import codec_regs_pkg::*;
#(
  parameter int unsigned N_DIRECT = 16,
  parameter int unsigned N_IND    = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned AW = $clog2(N_DIRECT),
  localparam int unsigned IW = $clog2(N_IND)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_en,
  input  logic [AW-1:0]                   rd_word,
  input  logic [IW-1:0]                   ptr,
  input  logic [N_DIRECT-1:0][DATA_W-1:0] words,
  input  logic [N_IND-1:0][IND_W-1:0]     ind_regs,
  output logic [DATA_W-1:0]               rdata
);
  logic [DATA_W-1:0] rd_next;
  logic              win_hidden;

  assign win_hidden = !ind_readable(int'(ptr));

  always_comb begin
    if (rd_word == AW'(WORD_WIN))
      rd_next = win_hidden ? '0 : DATA_W'(ind_regs[ptr]);
    else
      rd_next = words[rd_word];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_next;
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  assert_hidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_word == AW'(WORD_WIN) && ptr == IW'(IDX_HIDDEN)) |=> rdata == '0);
  assert_zext_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_word == AW'(WORD_WIN)) |=> rdata[DATA_W-1:IND_W] == '0);
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
  import codec_regs_pkg::*;
#(
  parameter int unsigned N_DIRECT = 16,
  parameter int unsigned N_IND    = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned AW     = $clog2(N_DIRECT),
  localparam int unsigned IW     = $clog2(N_IND),
  localparam int unsigned ADDR_W = AW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [AW-1:0]                   word;
  logic                            unused_lanes;
  logic                            win_wr;
  logic                            soft_clear;
  logic [IW-1:0]                   ptr;
  logic [N_DIRECT-1:0][DATA_W-1:0] words;
  logic [N_IND-1:0][IND_W-1:0]     ind_regs;

  assign word         = addr[ADDR_W-1:2];
  assign unused_lanes = ^addr[1:0];
  assign win_wr       = wr_en && word == AW'(WORD_WIN);
  assign soft_clear   = wr_en && word == AW'(WORD_CTL) && wdata[0];
  assign ptr          = words[WORD_PTR][IW-1:0];
  assign irq          = 1'b0;

  codec_direct_bank #(.N_DIRECT(N_DIRECT), .DATA_W(DATA_W)) u_direct (
    .clk(clk), .rst_n(rst_n), .clear(soft_clear), .wr_en(wr_en),
    .wr_word(word), .wr_val(wdata), .words(words)
  );

  codec_indirect_bank #(.N_IND(N_IND)) u_ind (
    .clk(clk), .rst_n(rst_n), .clear(soft_clear), .wr_en(win_wr),
    .wr_idx(ptr), .wr_val(wdata[IND_W-1:0]), .regs(ind_regs)
  );

  codec_read_port #(.N_DIRECT(N_DIRECT), .N_IND(N_IND), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_word(word), .ptr(ptr),
    .words(words), .ind_regs(ind_regs), .rdata(rdata)
  );

  assert_irq_low_R10: assert property (@(posedge clk) irq == 1'b0);
  assert_ctl_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == AW'(WORD_CTL)) |=>
      words[WORD_CTL] == ($past(wdata) & DATA_W'(CTL_MASK)));
  assert_clear_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clear |=> words[WORD_PTR] == '0);
  assert_clear_ind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clear |=> ind_regs[0] == '0);
  assert_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && word == AW'(WORD_LOCK)) |=> rdata == '0);
endmodule

// File: tb/codec_regfile_test.sv
`timescale 1ns/1ps
module codec_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  codec_regfile uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rdwr(input logic [5:0] a, input logic [31:0] d,
                      input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr = a; wdata = d; rd_en = 1'b1; wr_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic win_rd(input logic [4:0] idx, input logic [31:0] exp, input string tag);
    wr(6'h00, {27'd0, idx});
    rd(6'h04, exp, tag);
  endtask

  task automatic win_wr(input logic [4:0] idx, input logic [31:0] d);
    wr(6'h00, {27'd0, idx});
    wr(6'h04, d);
  endtask

  // monitor: pops the scoreboard one cycle after each read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en && rst_n) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check("R9 unexpected read", rdata, 32'hx);
        end else begin
          check(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after reset", rdata, 32'h0);
    check("R10 irq low", {31'd0, irq}, 32'h0);

    rd(6'h00, 32'h0, "R1 word0 reset");
    rd(6'h0C, 32'h0, "R1 word3 reset");
    rd(6'h04, 32'h0, "R1 index0 reset");
    win_rd(5'd12, 32'h8A, "R1 index12 reset");
    win_rd(5'd25, 32'hA0, "R1 index25 reset");

    wr(6'h14, 32'hDEADBEEF);
    rd(6'h14, 32'hDEADBEEF, "R2 word5 readback");
    wr(6'h3C, 32'h12345678);
    rd(6'h3C, 32'h12345678, "R2 word15 readback");
    rd(6'h17, 32'hDEADBEEF, "R2 low addr bits ignored");

    wr(6'h00, 32'hFFFFFFE7);
    rd(6'h00, 32'hFFFFFFE7, "R3 pointer keeps 32 bits");
    wr(6'h04, 32'h000001A5);
    rd(6'h04, 32'h000000A5, "R11 window zero-extend");
    win_wr(5'd8, 32'h3C);
    win_rd(5'd8, 32'h3C, "R3 index8 window");
    win_rd(5'd7, 32'hA5, "R3 index7 untouched");

    win_wr(5'd3, 32'h55);
    rd(6'h04, 32'h0, "R4 index3 reads zero");
    win_rd(5'd2, 32'h0, "R4 neighbour not written");

    win_wr(5'd11, 32'hFF);
    rd(6'h04, 32'h0, "R5 index11 write ignored");
    win_wr(5'd25, 32'h00);
    rd(6'h04, 32'hA0, "R5 index25 write ignored");

    win_wr(5'd12, 32'hFF);
    rd(6'h04, 32'hCA, "R6 index12 all ones");
    wr(6'h04, 32'h00);
    rd(6'h04, 32'h8A, "R6 index12 zero");
    wr(6'h04, 32'h40);
    rd(6'h04, 32'hCA, "R6 index12 keep bit6");

    wr(6'h08, 32'hFFFFFFFF);
    rd(6'h08, 32'h0, "R7 word2 write ignored");

    wr(6'h10, 32'hFFFFFF80);
    rd(6'h10, 32'h0, "R8 word4 masked");
    rd(6'h14, 32'hDEADBEEF, "R8 no clear when bit0 low");
    wr(6'h10, 32'h000000FE);
    rd(6'h10, 32'h7E, "R8 word4 low seven bits");
    wr(6'h10, 32'hFFFFFF83);
    rd(6'h10, 32'h03, "R8 word4 kept after clear");
    rd(6'h14, 32'h0, "R8 word5 cleared");
    rd(6'h00, 32'h0, "R8 pointer cleared");
    rd(6'h04, 32'h0, "R8 index0 cleared");
    win_rd(5'd12, 32'h8A, "R8 index12 restored");
    win_rd(5'd8, 32'h0, "R8 index8 cleared");
    win_rd(5'd25, 32'hA0, "R8 index25 restored");

    wr(6'h18, 32'h11);
    rdwr(6'h18, 32'h22, 32'h11, "R9 read before write");
    rd(6'h18, 32'h22, "R9 new value");
    repeat (3) @(negedge clk);
    check("R9 rdata holds", rdata, 32'h22);
    wr(6'h18, 32'h33);
    @(negedge clk);
    check("R9 rdata holds over write", rdata, 32'h22);
    check("R10 irq still low", {31'd0, irq}, 32'h0);

    @(negedge clk);
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R9 reads missing actual=%0d expected=0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule